// File: doc/BRIEF.md
# Control-Word Register Datapath

This block is an 8-bit register datapath that carries out one register-transfer operation per clock. A single 16-bit control word selects the operation. The word names two source registers and one destination register. It chooses whether the second operand comes from a register or from a constant input, and it picks the function-unit operation. It also chooses whether the value written back is the function result or the data-in bus, and whether a write happens at all.

The register file holds eight registers, with two combinational read ports and one write port. The first read port drives the address output. The selected second operand drives the data-out output. Status flags describe the function-unit result of the current cycle. A write lands on the next rising clock edge.

The datapath takes a new control word on every clock and has no back-pressure, because every operation completes in one cycle. For that reason the block has no valid/ready pair: all pins are plain control and data pins.

Top module: `cw_datapath`

## Requirements
- R1: The control word is packed as follows: bits 15:13 are the destination register, bits 12:10 the A-source register, bits 9:7 the B-source register, bit 6 the operand select (1 = constant input), bits 5:2 the function code, bit 1 the write-back select (1 = data-in bus), and bit 0 the write enable.
- R2: When the write enable is 1, the destination register takes the write-back value on the next rising clock edge. When the write enable is 0, no register changes.
- R3: Reading a register in the same cycle that it is being written returns the value it held before that edge.
- R4: `addr_out` equals the register named by the A-source field. `dout` equals `const_in` when the operand select is 1, and otherwise equals the register named by the B-source field.
- R5: Function codes 0 to 7 are adder operations on A and B: 0 gives A, 1 gives A+1, 2 gives A+B, 3 gives A+B+1, 4 gives A+~B, 5 gives A-B, 6 gives A-1, and 7 gives A with the carry set.
- R6: Function codes 8 to 11 are bitwise operations: 8 is A AND B, 9 is A OR B, 10 is A XOR B, and 11 is NOT A.
- R7: Function codes 12 and 15 pass B through unchanged. Code 13 shifts B right by one bit and code 14 shifts B left by one bit, with a zero shifted in.
- R8: The write-back value is the function result when the write-back select is 0, and `din` when it is 1.
- R9: `flag_n` is the result MSB and `flag_z` is 1 when the result is zero. For codes 0 to 7, `flag_c` is the adder carry-out and `flag_v` is two's-complement overflow. For codes 8 to 15, both `flag_c` and `flag_v` are 0.
- R10: A low `rst_n` clears every register to zero at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; registers update on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| control | input | 16 | Control word for the current cycle |
| const_in | input | 8 | Constant operand for the B side |
| din | input | 8 | External data for write-back |
| addr_out | output | 8 | Value on the A read port |
| dout | output | 8 | Selected B operand |
| flag_c | output | 1 | Carry-out of the adder operations |
| flag_v | output | 1 | Signed overflow of the adder operations |
| flag_n | output | 1 | Result sign bit |
| flag_z | output | 1 | Result is zero |

## Verification
Directed operand pairs 0x7F and 0x81 run through every function code. These values separate carry from overflow: an add that wraps to zero sets C but not V, while the subtract and increment set V but not C. They also show a wrong shift direction or fill bit, because the bits at both ends of 0x81 are set. A same-cycle write-and-read of one register separates old-value reads from forwarding. A constant-select cycle separates the constant path from the B register. Random control words, with data-in and constant values, then run long sequences of mixed writes and reads. Every port is compared against a bench model of the register file and the function table, which catches a wrong field decode or a write to the wrong register.

// File: rtl/cw_pkg.sv
package cw_pkg;
  localparam int DATA_W = 8;
  localparam int RA_W   = 3;
  localparam int FS_W   = 4;
  localparam int CW_W   = 3 * RA_W + FS_W + 3;

  typedef struct packed {
    logic [RA_W-1:0] dest;
    logic [RA_W-1:0] a_sel;
    logic [RA_W-1:0] b_sel;
    logic            b_const;
    logic [FS_W-1:0] func;
    logic            take_din;
    logic            wr_en;
  } cw_t;

  typedef enum logic [FS_W-1:0] {
    FS_PASS_A  = 4'd0,  FS_INC    = 4'd1,  FS_ADD   = 4'd2,  FS_ADD_C  = 4'd3,
    FS_ADD_NB  = 4'd4,  FS_SUB    = 4'd5,  FS_DEC   = 4'd6,  FS_A_C    = 4'd7,
    FS_AND     = 4'd8,  FS_OR     = 4'd9,  FS_XOR   = 4'd10, FS_NOT    = 4'd11,
    FS_PASS_B  = 4'd12, FS_SHR    = 4'd13, FS_SHL   = 4'd14, FS_PASS_B2 = 4'd15
  } fs_e;
endpackage

// File: rtl/cw_regfile.sv
module cw_regfile #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] wa,
  input  logic [DATA_W-1:0] wd,
  input  logic [ADDR_W-1:0] ra_a,
  input  logic [ADDR_W-1:0] ra_b,
  output logic [DATA_W-1:0] rd_a,
  output logic [DATA_W-1:0] rd_b
);
  localparam int NREGS = 1 << ADDR_W;

  logic [DATA_W-1:0] regs [NREGS];

  for (genvar i = 0; i < NREGS; i++) begin : g_reg
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        q <= '0;
      else if (we && wa == ADDR_W'(i))   q <= wd;
    end
    assign regs[i] = q;
  end

  assign rd_a = regs[ra_a];
  assign rd_b = regs[ra_b];
endmodule

// File: rtl/cw_func_unit.sv
module cw_func_unit
  import cw_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [FS_W-1:0]   fs,
  output logic [DATA_W-1:0] f,
  output logic              c,
  output logic              v,
  output logic              n,
  output logic              z
);
  logic [DATA_W-1:0] y;
  logic [DATA_W:0]   sum;
  logic              arith;

  assign arith = ~fs[FS_W-1];

  always_comb begin
    unique case (fs[2:1])
      2'd0: y = '0;
      2'd1: y = b;
      2'd2: y = ~b;
      default: y = '1;
    endcase
  end

  assign sum = {1'b0, a} + {1'b0, y} + {{DATA_W{1'b0}}, fs[0]};

  always_comb begin
    if (arith) begin
      f = sum[DATA_W-1:0];
    end else begin
      unique case (fs[2:0])
        3'd0:    f = a & b;
        3'd1:    f = a | b;
        3'd2:    f = a ^ b;
        3'd3:    f = ~a;
        3'd5:    f = b >> 1;
        3'd6:    f = b << 1;
        default: f = b;
      endcase
    end
  end

  assign c = arith & sum[DATA_W];
  assign v = arith & (a[DATA_W-1] == y[DATA_W-1]) & (sum[DATA_W-1] != a[DATA_W-1]);
  assign n = f[DATA_W-1];
  assign z = (f == '0);
endmodule

// File: rtl/cw_datapath.sv
module cw_datapath
  import cw_pkg::*;
#(
  parameter int DATA_W = cw_pkg::DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CW_W-1:0]   control,
  input  logic [DATA_W-1:0] const_in,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] addr_out,
  output logic [DATA_W-1:0] dout,
  output logic              flag_c,
  output logic              flag_v,
  output logic              flag_n,
  output logic              flag_z
);
  cw_t               cw;
  logic [DATA_W-1:0] rd_a, rd_b, b_op, fu_out, wb_val;

  assign cw = cw_t'(control);

  cw_regfile #(.DATA_W(DATA_W), .ADDR_W(RA_W)) i_regs (
    .clk (clk), .rst_n (rst_n), .we (cw.wr_en), .wa (cw.dest), .wd (wb_val),
    .ra_a (cw.a_sel), .ra_b (cw.b_sel), .rd_a (rd_a), .rd_b (rd_b)
  );

  assign b_op = cw.b_const ? const_in : rd_b;

  cw_func_unit #(.DATA_W(DATA_W)) i_fu (
    .a (rd_a), .b (b_op), .fs (cw.func), .f (fu_out),
    .c (flag_c), .v (flag_v), .n (flag_n), .z (flag_z)
  );

  assign wb_val   = cw.take_din ? din : fu_out;
  assign addr_out = rd_a;
  assign dout     = b_op;
endmodule

// File: rtl/cw_datapath_chk.sv
module cw_datapath_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [15:0]       control,
  input logic [DATA_W-1:0] din,
  input logic [DATA_W-1:0] addr_out,
  input logic [DATA_W-1:0] dout,
  input logic              flag_z
);
  logic [2:0] dest, a_sel, b_sel;
  logic       b_const, take_din, wr_en;
  logic [3:0] func;

  assign dest     = control[15:13];
  assign a_sel    = control[12:10];
  assign b_sel    = control[9:7];
  assign b_const  = control[6];
  assign func     = control[5:2];
  assign take_din = control[1];
  assign wr_en    = control[0];

  // R8
  din_writeback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && take_din) ##1 (a_sel == $past(dest)) |-> addr_out == $past(din));

  // R2
  no_write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en) ##1 (a_sel == $past(a_sel)) |-> $stable(addr_out));

  // R4
  same_port_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!b_const && b_sel == a_sel) |-> dout == addr_out);

  // R9
  nonzero_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !take_din && !flag_z) ##1 (a_sel == $past(dest)) |-> addr_out != '0);

  // R5
  pass_a_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !take_din && func == 4'd0) ##1 (a_sel == $past(dest)) |-> addr_out == $past(addr_out));

  // R10
  reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> addr_out == '0);
endmodule

bind cw_datapath cw_datapath_chk #(.DATA_W(DATA_W)) i_chk (
  .clk (clk), .rst_n (rst_n), .control (control), .din (din),
  .addr_out (addr_out), .dout (dout), .flag_z (flag_z)
);

// File: tb/test_cw_datapath.sv
module test_cw_datapath;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0;
  logic [15:0] control = '0;
  logic [7:0]  const_in = '0, din = '0;
  logic [7:0]  addr_out, dout;
  logic        flag_c, flag_v, flag_n, flag_z;

  int total = 0, fails = 0;
  logic [7:0] m_regs [8];
  logic [7:0] e_addr, e_dout, e_f;
  logic       e_c, e_v;

  cw_datapath i_cw_datapath (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [9:0] fu_ref(input logic [3:0] fs, input logic [7:0] a, input logic [7:0] b);
    int sa, sb, ex;
    logic [7:0] r;
    logic c, v;
    sa = $signed(a); sb = $signed(b); ex = 0; c = 0; v = 0;
    case (fs)
      0: begin r = a;         ex = sa;          c = 0;           end
      1: begin r = a + 1;     ex = sa + 1;      c = (a == 8'hFF); end
      2: begin r = a + b;     ex = sa + sb;     c = (int'(a) + int'(b) > 255); end
      3: begin r = a + b + 1; ex = sa + sb + 1; c = (int'(a) + int'(b) + 1 > 255); end
      4: begin r = a - b - 1; ex = sa - sb - 1; c = (a > b);      end
      5: begin r = a - b;     ex = sa - sb;     c = (a >= b);     end
      6: begin r = a - 1;     ex = sa - 1;      c = (a != 0);     end
      7: begin r = a;         ex = sa;          c = 1;           end
      8: r = a & b;
      9: r = a | b;
      10: r = a ^ b;
      11: r = ~a;
      13: r = {1'b0, b[7:1]};
      14: r = {b[6:0], 1'b0};
      default: r = b;
    endcase
    if (fs < 8) v = (ex > 127) || (ex < -128);
    return {c, v, r};
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Drives one control word, computes expected outputs, then updates the model.
  task automatic step(input logic [2:0] d, input logic [2:0] a, input logic [2:0] b,
                      input logic mb, input logic [3:0] fs, input logic md, input logic we,
                      input logic [7:0] k, input logic [7:0] dn);
    logic [9:0] r;
    @(negedge clk);
    control = {d, a, b, mb, fs, md, we};   // R1 field order
    const_in = k; din = dn;
    #1;
    e_addr = m_regs[a];
    e_dout = mb ? k : m_regs[b];
    r = fu_ref(fs, e_addr, e_dout);
    {e_c, e_v, e_f} = r;
    if (we) m_regs[d] = md ? dn : e_f;
  endtask

  task automatic load(input logic [2:0] d, input logic [7:0] val);
    step(d, 0, 0, 0, 4'd0, 1, 1, 8'h00, val);
  endtask

  task automatic read_reg(input string tag, input logic [2:0] r, input logic [7:0] exp);
    step(0, r, 0, 0, 4'd0, 0, 0, 8'h00, 8'h00);
    chk(tag, addr_out, exp);
  endtask

  task automatic op(input string tag, input logic [3:0] fs, input logic [7:0] exp,
                    input logic ec, input logic ev);
    load(3'd1, 8'h7F);
    load(3'd2, 8'h81);
    step(3'd3, 3'd1, 3'd2, 0, fs, 0, 1, 8'h00, 8'h00);
    chk({tag, " C"}, 8'(flag_c), 8'(ec));
    chk({tag, " V"}, 8'(flag_v), 8'(ev));
    chk({tag, " N"}, 8'(flag_n), 8'(exp[7]));   // R9
    chk({tag, " Z"}, 8'(flag_z), 8'(exp == 0)); // R9
    read_reg(tag, 3'd3, exp);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++; total++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 8; i++) m_regs[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R10: every register reads zero after reset
    for (int i = 0; i < 8; i++) read_reg("R10 reset", 3'(i), 8'h00);

    // R8 / R2: load via din, then read back
    for (int i = 0; i < 8; i++) load(3'(i), 8'(8'h10 * i + 3));
    for (int i = 0; i < 8; i++) read_reg("R8 din load", 3'(i), 8'(8'h10 * i + 3));

    // R2: write disabled leaves register unchanged
    step(3'd4, 0, 0, 0, 4'd0, 1, 0, 8'h00, 8'hEE);
    read_reg("R2 no write", 3'd4, 8'h43);

    // R3: same-cycle read returns old value, then new
    step(3'd5, 3'd5, 3'd5, 0, 4'd0, 1, 1, 8'h00, 8'hA5);
    chk("R3 old value A", addr_out, 8'h53);
    chk("R3 old value B", dout, 8'h53);
    read_reg("R3 new value", 3'd5, 8'hA5);

    // R4: constant select versus register B
    step(0, 3'd1, 3'd2, 1, 4'd12, 0, 0, 8'h3C, 8'h00);
    chk("R4 const dout", dout, 8'h3C);
    step(0, 3'd1, 3'd2, 0, 4'd12, 0, 0, 8'h3C, 8'h00);
    chk("R4 reg dout", dout, 8'h23);
    chk("R4 addr_out", addr_out, 8'h13);

    // R1: R1 <- R2 + R3 with register operand, function result written
    load(3'd2, 8'h21); load(3'd3, 8'h14);
    step(3'd1, 3'd2, 3'd3, 0, 4'd2, 0, 1, 8'h00, 8'h00);
    read_reg("R1 add encoding", 3'd1, 8'h35);

    // R5 arithmetic, R6 logic, R7 shift/pass on A=7F, B=81
    op("R5 add",  4'd2,  8'h00, 1, 0);
    op("R5 sub",  4'd5,  8'hFE, 0, 1);
    op("R5 inc",  4'd1,  8'h80, 0, 1);
    op("R5 dec",  4'd6,  8'h7E, 1, 0);
    op("R5 addnb",4'd4,  8'hFD, 0, 1);
    op("R5 addc", 4'd3,  8'h01, 1, 0);
    op("R5 passa",4'd0,  8'h7F, 0, 0);
    op("R5 passac",4'd7, 8'h7F, 1, 0);
    op("R6 and",  4'd8,  8'h01, 0, 0);
    op("R6 or",   4'd9,  8'hFF, 0, 0);
    op("R6 xor",  4'd10, 8'hFE, 0, 0);
    op("R6 not",  4'd11, 8'h80, 0, 0);
    op("R7 passb",4'd12, 8'h81, 0, 0);
    op("R7 shr",  4'd13, 8'h40, 0, 0);
    op("R7 shl",  4'd14, 8'h02, 0, 0);
    op("R7 passb2",4'd15,8'h81, 0, 0);

    // Random mix checked against the bench model (R4, R5, R9)
    for (int n = 0; n < 600; n++) begin
      logic [15:0] w;
      w = 16'($urandom);
      step(w[15:13], w[12:10], w[9:7], w[6], w[5:2], w[1], w[0],
           8'($urandom), 8'($urandom));
      chk("R4 rand addr", addr_out, e_addr);
      chk("R4 rand dout", dout, e_dout);
      chk("R9 rand C", 8'(flag_c), 8'(e_c));
      chk("R9 rand V", 8'(flag_v), 8'(e_v));
      chk("R9 rand N", 8'(flag_n), 8'(e_f[7]));
      chk("R9 rand Z", 8'(flag_z), 8'(e_f == 0));
    end

    // R10: asynchronous reset mid-run
    @(negedge clk);
    control = {3'd0, 3'd1, 3'd1, 1'b0, 4'd0, 1'b0, 1'b0};
    load(3'd1, 8'h99);
    @(negedge clk);
    control = {3'd0, 3'd1, 3'd1, 1'b0, 4'd0, 1'b0, 1'b0};
    #1 rst_n = 0;
    #1 chk("R10 async clear", addr_out, 8'h00);
    for (int i = 0; i < 8; i++) m_regs[i] = '0;
    @(negedge clk) rst_n = 1;
    read_reg("R10 after reset", 3'd1, 8'h00);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule